// File: doc/BRIEF.md
# Alarm Clock Controller

This block keeps time for an alarm clock and decides when the alarm sounds. A prescaler turns a chosen number of system clocks into one minute. A minute counter steps through a 24-hour day, from 0 to 1439, and then wraps. When the count enters the minute that `wake_time` selects, and the arming level is high, the controller starts ringing. It keeps ringing until one of these things happens:

- the user presses snooze, and the alarm comes back after five minutes;
- the user presses stop;
- the arming level drops.

The controller is a three-state machine: idle, ringing and snoozing. The state register is one-hot encoded. `alarm_on` is high exactly while the machine is in the ringing state. A snooze press is edge-detected, so holding the button down counts as one press. Stop, or a low arming level, sends the machine back to idle and cancels any snooze that is pending. After that, only a new entry into the wake minute starts the ringing again.

Top module: `alarm_ctrl`

## Requirements
- R1: After reset is released the minute count starts at 0. It advances by one on every `TICKS_PER_MIN`-th rising edge, and the first advance happens on edge number `TICKS_PER_MIN`.
- R2: If `arm_en` is high and `stop_in` is low, `alarm_on` rises on the edge after the edge on which the count entered the minute equal to `wake_time`. A minute 0 that is present only because of reset counts as no entry. If `arm_en` is low at that point, there is no ring.
- R3: When `arm_en` is low at a rising edge, `alarm_on` is low after that edge, from any state. The machine goes to idle and does not ring again until the next entry into the wake minute.
- R4: A rising edge of `snooze_in` sampled while ringing drives `alarm_on` low after that edge. `alarm_on` goes high again exactly `SNOOZE_MIN*TICKS_PER_MIN` edges later.
- R5: A snooze pulse held high for several cycles counts once. Every new press while ringing repeats the R4 behaviour.
- R6: When `stop_in` is high at a rising edge, `alarm_on` is low after that edge and any pending snooze is cancelled.
- R7: A snooze press while idle or snoozing has no effect, so `alarm_on` stays low.
- R8: The count wraps from `MIN_PER_DAY-1` to 0. A `wake_time` of 0 rings one edge after that wrap.
- R9: Under reset (`rst_n` low, synchronous) `alarm_on` is low and the machine is idle (one-hot code 3'b001). The state register always holds exactly one set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| arm_en | input | 1 | Arming level; low silences the alarm and disarms it |
| snooze_in | input | 1 | Snooze button, edge-detected |
| stop_in | input | 1 | Stop button, level sampled each edge |
| wake_time | input | $clog2(MIN_PER_DAY) | Alarm minute of the day, 0 to MIN_PER_DAY-1 |
| alarm_on | output | 1 | High while the alarm rings |

## Verification
The bench counts edges from reset release and checks `alarm_on` on the exact edge where ringing should begin, and on the edge before it. A prescaler or match path that is off by one edge fails there.

A snooze held for three cycles must bring the alarm back on the same edge as a one-cycle press. A design that re-triggers on the level would come back two edges late.

The bench drops `arm_en` or raises stop while the machine is snoozing, then waits past the point where the snooze would have ended. A design that keeps the snooze timer running rings again by mistake.

A wake minute of 0 is tested across the day wrap. This catches a counter that wraps at the wrong count, and a design that rings on the reset value.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  // One-hot state codes of the controller
  typedef enum logic [2:0] {
    ST_IDLE   = 3'b001,
    ST_RING   = 3'b010,
    ST_SNOOZE = 3'b100
  } alm_state_e;

  // Increment modulo lim
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // Cycles spent in the snooze state
  function automatic int unsigned snooze_cycles(input int unsigned mins, input int unsigned ticks);
    return mins * ticks;
  endfunction
endpackage

// File: rtl/alarm_tick_gen.sv
module alarm_tick_gen #(
  parameter int TICKS_PER_MIN = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;
  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == W'(TICKS_PER_MIN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/alarm_minute_ctr.sv
module alarm_minute_ctr #(
  parameter int MIN_PER_DAY = 1440,
  localparam int MIN_W = $clog2(MIN_PER_DAY)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [MIN_W-1:0] min_q,
  output logic             min_new
);
  logic [MIN_W-1:0] min_d;

  assign min_d = MIN_W'(alarm_pkg::wrap_inc(32'(min_q), MIN_PER_DAY));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      min_q   <= '0;
      min_new <= 1'b0;
    end else begin
      min_new <= tick;
      if (tick) min_q <= min_d;
    end
  end
endmodule

// File: rtl/alarm_fsm.sv
module alarm_fsm
  import alarm_pkg::*;
#(
  parameter int TICKS_PER_MIN = 1,
  parameter int SNOOZE_MIN    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_en,
  input  logic       stop_in,
  input  logic       snooze_rise,
  input  logic       match_evt,
  output alm_state_e state_q,
  output logic       snz_done,
  output logic       alarm_on
);
  localparam int SNZ_CYC = snooze_cycles(SNOOZE_MIN, TICKS_PER_MIN);
  localparam int SW      = $clog2(SNZ_CYC + 1);

  alm_state_e    state_d;
  logic [SW-1:0] snz_cnt;

  assign snz_done = (state_q == ST_SNOOZE) && (snz_cnt == '0);
  assign alarm_on = (state_q == ST_RING);

  always_comb begin
    state_d = state_q;
    if (!arm_en || stop_in) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:   if (match_evt)   state_d = ST_RING;
        ST_RING:   if (snooze_rise) state_d = ST_SNOOZE;
        ST_SNOOZE: if (snz_done)    state_d = ST_RING;
        default:                    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      snz_cnt <= '0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_SNOOZE && state_d == ST_SNOOZE) snz_cnt <= SW'(SNZ_CYC - 1);
      else if (state_d != ST_SNOOZE)                    snz_cnt <= '0;
      else                                              snz_cnt <= snz_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int TICKS_PER_MIN = 1,
  parameter int MIN_PER_DAY   = 1440,
  parameter int SNOOZE_MIN    = 5,
  localparam int MIN_W = $clog2(MIN_PER_DAY)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_en,
  input  logic             snooze_in,
  input  logic             stop_in,
  input  logic [MIN_W-1:0] wake_time,
  output logic             alarm_on
);
  logic             min_tick;
  logic [MIN_W-1:0] min_q;
  logic             min_new;
  logic             snz_q;
  logic             snooze_rise;
  logic             match_evt;
  logic             snz_done;
  alm_state_e       state_q;

  alarm_tick_gen #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(min_tick));

  alarm_minute_ctr #(.MIN_PER_DAY(MIN_PER_DAY)) u_min (
    .clk(clk), .rst_n(rst_n), .tick(min_tick), .min_q(min_q), .min_new(min_new));

  always_ff @(posedge clk) begin
    if (!rst_n) snz_q <= 1'b0;
    else        snz_q <= snooze_in;
  end

  assign snooze_rise = snooze_in & ~snz_q;
  assign match_evt   = min_new && (min_q == wake_time);

  alarm_fsm #(.TICKS_PER_MIN(TICKS_PER_MIN), .SNOOZE_MIN(SNOOZE_MIN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .arm_en(arm_en), .stop_in(stop_in),
    .snooze_rise(snooze_rise), .match_evt(match_evt),
    .state_q(state_q), .snz_done(snz_done), .alarm_on(alarm_on));
endmodule

// File: rtl/alarm_ctrl_chk.sv
module alarm_ctrl_chk #(
  parameter int MIN_PER_DAY = 1440,
  localparam int MIN_W = $clog2(MIN_PER_DAY)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm_en,
  input logic             stop_in,
  input logic             alarm_on,
  input logic [2:0]       state,
  input logic             snooze_rise,
  input logic             match_evt,
  input logic             snz_done,
  input logic             min_tick,
  input logic [MIN_W-1:0] min_q
);
  p_onehot_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state) == 1);

  p_disarm_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_en |=> !alarm_on);

  p_stop_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_in |=> !alarm_on);

  p_ring_on_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'b001 && match_evt && arm_en && !stop_in) |=> alarm_on);

  p_snooze_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_on && snooze_rise && arm_en && !stop_in) |=> (!alarm_on && state == 3'b100));

  p_snooze_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (snz_done && arm_en && !stop_in) |=> alarm_on);

  p_no_stray_ring_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_on) |-> ($past(match_evt) || $past(snz_done)));

  p_day_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (min_tick && min_q == MIN_W'(MIN_PER_DAY - 1)) |=> (min_q == '0));
endmodule

bind alarm_ctrl alarm_ctrl_chk #(.MIN_PER_DAY(MIN_PER_DAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_en(arm_en), .stop_in(stop_in),
  .alarm_on(alarm_on), .state(state_q), .snooze_rise(snooze_rise),
  .match_evt(match_evt), .snz_done(snz_done), .min_tick(min_tick), .min_q(min_q));

// File: tb/alarm_ctrl_tb_top.sv
`timescale 1ns/1ps
module alarm_ctrl_tb_top;
  localparam int T   = 4;     // clocks per minute in this bench
  localparam int MPD = 1440;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm_en = 1'b0, snooze_in = 1'b0, stop_in = 1'b0;
  logic [10:0] wake_time = '0;
  logic        alarm_on;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  alarm_ctrl #(.TICKS_PER_MIN(T), .MIN_PER_DAY(MPD), .SNOOZE_MIN(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm_en(arm_en), .snooze_in(snooze_in),
    .stop_in(stop_in), .wake_time(wake_time), .alarm_on(alarm_on));

  typedef struct packed {
    logic [7:0] wait_n;
    logic       arm, snz, stp, exp;
    logic [3:0] req;
  } vec_t;

  // wake_time = 3, T = 4: ring after edge 13, snooze = 20 edges
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{8'd12, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 n=12 not yet
    '{8'd1,  1'b1, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 n=13 rings
    '{8'd1,  1'b1, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 n=14 snooze drops
    '{8'd2,  1'b1, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 n=16 held press
    '{8'd16, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 n=32
    '{8'd1,  1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 n=33
    '{8'd1,  1'b1, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 n=34 back on
    '{8'd1,  1'b1, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 n=35 second press
    '{8'd19, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 n=54
    '{8'd1,  1'b1, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 n=55 back on
    '{8'd1,  1'b1, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 n=56 stop
    '{8'd10, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 n=66 stays off
    '{8'd1,  1'b1, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 n=67 idle snooze
    '{8'd30, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7}   // R7 n=97 still off
  };

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (alarm_on !== exp) begin
      errors++;
      $display("FAIL %s: alarm_on=%b expected %b", tag, alarm_on, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Reset, then release at a negedge: edge count 0 from here
  task automatic do_reset(input logic [10:0] wt, input logic arm);
    @(negedge clk);
    rst_n = 1'b0; snooze_in = 1'b0; stop_in = 1'b0;
    wake_time = wt; arm_en = arm;
    step(3);
    chk(1'b0, "R9 reset state");
    rst_n = 1'b1;
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    do_reset(11'd3, 1'b1);
    for (int i = 0; i < NV; i++) begin
      arm_en = VEC[i].arm; snooze_in = VEC[i].snz; stop_in = VEC[i].stp;
      step(int'(VEC[i].wait_n));
      chk(VEC[i].exp, $sformatf("vec%0d R%0d (R1 time base)", i, VEC[i].req));
    end
    snooze_in = 1'b0; stop_in = 1'b0;

    // R3: disarm while ringing, no re-ring in same minute
    do_reset(11'd2, 1'b1);
    step(8);  chk(1'b0, "R1 edge before ring");
    step(1);  chk(1'b1, "R2 ring at edge 9");
    arm_en = 1'b0; step(1); chk(1'b0, "R3 disarm while ringing");
    arm_en = 1'b1; step(20); chk(1'b0, "R3 no re-ring after rearm");

    // R3: disarm during snooze cancels it (would ring at 26)
    do_reset(11'd1, 1'b1);
    step(5);  chk(1'b1, "R2 ring at edge 5");
    snooze_in = 1'b1; step(1); snooze_in = 1'b0; chk(1'b0, "R4 snooze");
    arm_en = 1'b0; step(1); arm_en = 1'b1;
    step(23); chk(1'b0, "R3 snooze cancelled by disarm");

    // R6: stop during snooze cancels it
    do_reset(11'd1, 1'b1);
    step(5);
    snooze_in = 1'b1; step(1); snooze_in = 1'b0;
    stop_in = 1'b1; step(1); stop_in = 1'b0;
    step(23); chk(1'b0, "R6 snooze cancelled by stop");

    // R2: unarmed at match never rings
    do_reset(11'd1, 1'b0);
    step(5); arm_en = 1'b1; step(5); chk(1'b0, "R2 unarmed at match");

    // R8: wake at minute 0 rings after day wrap, not at reset
    do_reset(11'd0, 1'b1);
    step(3);         chk(1'b0, "R8 no ring on reset minute");
    step(MPD*T - 3); chk(1'b0, "R8 edge before wrap ring");
    step(1);         chk(1'b1, "R8 ring after wrap");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end
endmodule